// File: doc/BRIEF.md
# Dual Comparator Output Router

This block takes the digital results of two analog comparator channels and decides where each one goes. Every channel has a raw lookup output, which arrives on an input port, and a sticky latch that this block keeps. The latch is set while the raw output is high and holds that value until it is cleared. A single 8-bit control register picks three routes for each channel. It picks the raw or latched signal for the pin path. It picks the raw or latched signal for the data path, which feeds the sensing logic and the interrupt edge detector. It also picks how the channel's latch is cleared.

A latch is cleared in one of two ways: by software, through a write to the latch register, or by a rising edge on the other channel's raw output. A shared interrupt request pulses when an enabled channel's data path rises. The request is gated by an external mask input. The pin outputs are gated by an external pin-enable input.

Software reaches the control and latch registers through a plain write-enable and address bus with combinational read data. The block carries no streaming data, so every pin is a plain control or status signal with no valid/ready handshake.

Top module: `cmp_route`

## Requirements
- R1: After reset, the control register reads 0, both latches read 0 and `irq_pulse` is low.
- R2: A write with `bus_addr`=0 loads `bus_wdata` into the control register on the clock edge. Reading address 0 returns that register. Channel i uses four bits starting at bit 4i: data-select at 4i, reset-source at 4i+1, pin-select at 4i+2 and interrupt-enable at 4i+3.
- R3: A latch is set at the clock edge after any cycle in which its channel's `lut_in` bit is high. Reading address 1 returns {6'b0, latch1, latch0}.
- R4: While a channel's reset-source bit is 0, a write to address 1 with that channel's data bit at 0 clears its latch. A data bit of 1 leaves the latch unchanged. While the reset-source bit is 1, writes to address 1 have no effect on that latch.
- R5: While a channel's reset-source bit is 1, a rising edge of the other channel's `lut_in` clears its latch. A rising edge here means high in this cycle and low in the previous cycle.
- R6: If a set and a clear of a latch fall in the same cycle, the latch ends up set.
- R7: `data_out[i]` equals `lut_in[i]` when data-select is 0 and equals latch i when it is 1. It follows the current control and latch state combinationally.
- R8: `pin_out[i]` is 0 while `pin_en` is low. Otherwise it equals `lut_in[i]` when pin-select is 0 and latch i when pin-select is 1.
- R9: When a channel's interrupt-enable bit is 1 and its `data_out` bit is high in a cycle after being low in the previous cycle, `irq_pulse` is high for the following cycle, provided `irq_mask_en` was high in the edge cycle. Otherwise `irq_pulse` is low.
- R10: With both interrupt-enable bits set, a rising edge on either channel's data path alone raises `irq_pulse`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lut_in | input | 2 | Raw comparator lookup outputs, one bit per channel |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 1 | Register address: 0 control, 1 latch |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr` |
| irq_mask_en | input | 1 | External interrupt mask; 1 lets the request through |
| pin_en | input | 1 | External pin output enable |
| pin_out | output | 2 | Pin path per channel |
| data_out | output | 2 | Data path per channel, to sensing and interrupt |
| irq_pulse | output | 1 | Shared single-cycle interrupt request |

## Verification
Random toggling of `lut_in` under random control values covers every pairing of the select bits. It shows whether a raw signal has been swapped with a latched one, and whether the wrong channel's field is decoded. Directed sequences isolate three cases. In the first, a software clear arrives while reset-source is 1, which tells the two clear sources apart. In the second, the other channel rises while this channel's input is still high, which checks that a set outranks a clear. The third covers an interrupt edge with the mask low and edges on one channel at a time with both enables set, which separates the masking from the merge of the two channels.

// File: rtl/cmp_route_pkg.sv
package cmp_route_pkg;
  localparam int NUM_CH    = 2;
  localparam int FIELD_W   = 4;
  localparam int REG_W     = NUM_CH * FIELD_W;
  localparam int ADDR_W    = 1;
  localparam int DSEL_OFS  = 0;
  localparam int RSRC_OFS  = 1;
  localparam int PSEL_OFS  = 2;
  localparam int IE_OFS    = 3;

  typedef struct packed {
    logic ie;
    logic psel;
    logic rsrc;
    logic dsel;
  } chan_cfg_t;

  function automatic chan_cfg_t cfg_of(input logic [REG_W-1:0] r, input int ch);
    chan_cfg_t c;
    c.dsel = r[ch*FIELD_W + DSEL_OFS];
    c.rsrc = r[ch*FIELD_W + RSRC_OFS];
    c.psel = r[ch*FIELD_W + PSEL_OFS];
    c.ie   = r[ch*FIELD_W + IE_OFS];
    return c;
  endfunction
endpackage

// File: rtl/cmp_route_regs.sv
module cmp_route_regs
  import cmp_route_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [REG_W-1:0]  bus_wdata,
  input  logic [NUM_CH-1:0] latch_q,
  output logic [REG_W-1:0]  ctrl_q,
  output logic [NUM_CH-1:0] sw_clr,
  output logic [REG_W-1:0]  bus_rdata
);
  localparam logic [ADDR_W-1:0] A_CTRL  = '0;
  localparam logic [ADDR_W-1:0] A_LATCH = ADDR_W'(1);

  logic wr_ctrl, wr_latch;
  assign wr_ctrl  = bus_we && (bus_addr == A_CTRL);
  assign wr_latch = bus_we && (bus_addr == A_LATCH);

  always_ff @(posedge clk) begin
    if (!rst_n)       ctrl_q <= '0;
    else if (wr_ctrl) ctrl_q <= bus_wdata;
  end

  for (genvar i = 0; i < NUM_CH; i++) begin : g_clr
    assign sw_clr[i] = wr_latch && !bus_wdata[i];
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == A_CTRL) bus_rdata = ctrl_q;
    else                    bus_rdata[NUM_CH-1:0] = latch_q;
  end

  assert_ctrl_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ctrl |=> (ctrl_q == $past(bus_wdata)));
  assert_ctrl_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_ctrl && $past(rst_n)) |=> $stable(ctrl_q));
endmodule

// File: rtl/cmp_route_chan.sv
module cmp_route_chan
  import cmp_route_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      lut,
  input  chan_cfg_t cfg,
  input  logic      sw_clr,
  input  logic      other_rise,
  input  logic      pin_en,
  output logic      lut_rise,
  output logic      latch_q,
  output logic      data_o,
  output logic      pin_o
);
  logic lut_prev;
  logic clr;

  always_ff @(posedge clk) begin
    if (!rst_n) lut_prev <= 1'b0;
    else        lut_prev <= lut;
  end
  assign lut_rise = lut && !lut_prev;

  assign clr = cfg.rsrc ? other_rise : sw_clr;

  always_ff @(posedge clk) begin
    if (!rst_n)   latch_q <= 1'b0;
    else if (lut) latch_q <= 1'b1;
    else if (clr) latch_q <= 1'b0;
  end

  assign data_o = cfg.dsel ? latch_q : lut;
  assign pin_o  = pin_en && (cfg.psel ? latch_q : lut);

  assert_set_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
    lut |=> latch_q);
  assert_cross_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg.rsrc && other_rise && !lut) |=> !latch_q);
  assert_sw_ignored_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg.rsrc && !other_rise && latch_q) |=> latch_q);
endmodule

// File: rtl/cmp_route_irq.sv
module cmp_route_irq
  import cmp_route_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] data_i,
  input  logic [NUM_CH-1:0] ie,
  input  logic              mask_en,
  output logic              irq_pulse
);
  logic [NUM_CH-1:0] data_prev;
  logic [NUM_CH-1:0] rise;

  always_ff @(posedge clk) begin
    if (!rst_n) data_prev <= '0;
    else        data_prev <= data_i;
  end
  assign rise = data_i & ~data_prev & ie;

  always_ff @(posedge clk) begin
    if (!rst_n) irq_pulse <= 1'b0;
    else        irq_pulse <= mask_en && (|rise);
  end

  assert_irq_masked_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !mask_en |=> !irq_pulse);
  assert_irq_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_pulse && $past(rst_n)) |-> ($past(mask_en) && ($past(data_i & ie) != '0)));
endmodule

// File: rtl/cmp_route.sv
module cmp_route
  import cmp_route_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] lut_in,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [REG_W-1:0]  bus_wdata,
  output logic [REG_W-1:0]  bus_rdata,
  input  logic              irq_mask_en,
  input  logic              pin_en,
  output logic [NUM_CH-1:0] pin_out,
  output logic [NUM_CH-1:0] data_out,
  output logic              irq_pulse
);
  logic [REG_W-1:0]  ctrl_q;
  logic [NUM_CH-1:0] sw_clr, latch_q, lut_rise, ie;

  cmp_route_regs u_regs (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .latch_q(latch_q), .ctrl_q(ctrl_q),
    .sw_clr(sw_clr), .bus_rdata(bus_rdata)
  );

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    localparam int OTHER = (i + 1) % NUM_CH;
    chan_cfg_t cfg;
    assign cfg   = cfg_of(ctrl_q, i);
    assign ie[i] = cfg.ie;
    cmp_route_chan u_chan (
      .clk(clk), .rst_n(rst_n), .lut(lut_in[i]), .cfg(cfg),
      .sw_clr(sw_clr[i]), .other_rise(lut_rise[OTHER]), .pin_en(pin_en),
      .lut_rise(lut_rise[i]), .latch_q(latch_q[i]),
      .data_o(data_out[i]), .pin_o(pin_out[i])
    );
  end

  cmp_route_irq u_irq (
    .clk(clk), .rst_n(rst_n), .data_i(data_out), .ie(ie),
    .mask_en(irq_mask_en), .irq_pulse(irq_pulse)
  );

  assert_pin_gate_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !pin_en |-> (pin_out == '0));
endmodule

// File: tb/sim_cmp_route.sv
module sim_cmp_route;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] lut_in = '0;
  logic       bus_we = 1'b0;
  logic       bus_addr = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic       irq_mask_en = 1'b0;
  logic       pin_en = 1'b0;
  logic [1:0] pin_out, data_out;
  logic       irq_pulse;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // model state
  logic [7:0] m_ctrl;
  logic [1:0] m_latch, m_lut_prev, m_data_prev;
  logic       m_irq;

  always #4 clk = ~clk;

  cmp_route u0 (
    .clk(clk), .rst_n(rst_n), .lut_in(lut_in), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_mask_en(irq_mask_en), .pin_en(pin_en), .pin_out(pin_out),
    .data_out(data_out), .irq_pulse(irq_pulse)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic bitf(input logic [7:0] c, input int ch, input int ofs);
    return c[ch*4 + ofs];
  endfunction

  function automatic logic [1:0] exp_data(input logic [1:0] l);
    logic [1:0] r;
    for (int i = 0; i < 2; i++) r[i] = bitf(m_ctrl, i, 0) ? m_latch[i] : l[i];
    return r;
  endfunction

  function automatic logic [1:0] exp_pin(input logic [1:0] l, input logic en);
    logic [1:0] r;
    for (int i = 0; i < 2; i++) r[i] = en && (bitf(m_ctrl, i, 2) ? m_latch[i] : l[i]);
    return r;
  endfunction

  // Drive inputs at a falling edge, check outputs, then advance the model one clock.
  task automatic step(input logic [1:0] l, input logic we, input logic a,
                      input logic [7:0] wd, input logic msk, input logic pe);
    logic [1:0] d, rl, clr;
    lut_in = l; bus_we = we; bus_addr = a; bus_wdata = wd;
    irq_mask_en = msk; pin_en = pe;
    #1;
    d = exp_data(l);
    chk("R7 data_out", {6'b0, data_out}, {6'b0, d});
    chk("R8 pin_out", {6'b0, pin_out}, {6'b0, exp_pin(l, pe)});
    chk("R9 irq_pulse", {7'b0, irq_pulse}, {7'b0, m_irq});
    chk(a ? "R3 latch read" : "R2 ctrl read", bus_rdata,
        a ? {6'b0, m_latch} : m_ctrl);
    rl = l & ~m_lut_prev;
    for (int i = 0; i < 2; i++)
      clr[i] = bitf(m_ctrl, i, 1) ? rl[1-i] : (we && a && !wd[i]);
    m_irq = msk && (((d & ~m_data_prev) & {bitf(m_ctrl,1,3), bitf(m_ctrl,0,3)}) != 2'b0);
    m_latch = l | (m_latch & ~clr);
    m_data_prev = d;
    m_lut_prev = l;
    if (we && !a) m_ctrl = wd;
    @(negedge clk);
  endtask

  task automatic idle(input logic [1:0] l);
    step(l, 1'b0, 1'b1, 8'h00, 1'b1, 1'b1);
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [1:0] rl;
    logic [7:0] rw;
    void'($urandom(32'd1234));
    m_ctrl = '0; m_latch = '0; m_lut_prev = '0; m_data_prev = '0; m_irq = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1 reset state
    chk("R1 irq after reset", {7'b0, irq_pulse}, 8'h00);
    bus_addr = 1'b0; #1;
    chk("R1 ctrl after reset", bus_rdata, 8'h00);
    bus_addr = 1'b1; #1;
    chk("R1 latch after reset", bus_rdata, 8'h00);
    @(negedge clk);

    // R2 register layout: ch0 latched data, ch1 raw; write and read back
    step(2'b00, 1'b1, 1'b0, 8'h01, 1'b1, 1'b1);
    step(2'b00, 1'b0, 1'b0, 8'h00, 1'b1, 1'b1);
    chk("R2 ctrl readback", bus_rdata, 8'h01);

    // R3 latch sets; R4 software clear with reset-source 0
    step(2'b01, 1'b0, 1'b1, 8'h00, 1'b1, 1'b1);
    idle(2'b00);
    chk("R3 latch0 set", bus_rdata, 8'h01);
    step(2'b00, 1'b1, 1'b1, 8'h01, 1'b1, 1'b1);
    chk("R4 write 1 keeps latch", bus_rdata, 8'h01);
    step(2'b00, 1'b1, 1'b1, 8'h00, 1'b1, 1'b1);
    idle(2'b00);
    chk("R4 write 0 clears latch", bus_rdata, 8'h00);

    // R5: ch0 reset-source 1; ch1 rising edge clears latch0; sw write ignored (R4)
    step(2'b00, 1'b1, 1'b0, 8'h02, 1'b1, 1'b1);
    step(2'b01, 1'b0, 1'b1, 8'h00, 1'b1, 1'b1);
    step(2'b00, 1'b1, 1'b1, 8'h00, 1'b1, 1'b1);
    idle(2'b00);
    chk("R4 sw clear ignored when rsrc=1", bus_rdata & 8'h01, 8'h01);
    step(2'b10, 1'b0, 1'b1, 8'h00, 1'b1, 1'b1);
    idle(2'b00);
    chk("R5 cross clear latch0", bus_rdata & 8'h01, 8'h00);

    // R6: set and cross clear same cycle -> set wins
    step(2'b00, 1'b1, 1'b1, 8'h00, 1'b1, 1'b1);
    step(2'b01, 1'b0, 1'b1, 8'h00, 1'b1, 1'b1);
    step(2'b11, 1'b0, 1'b1, 8'h00, 1'b1, 1'b1);
    idle(2'b00);
    chk("R6 set beats clear", bus_rdata & 8'h01, 8'h01);

    // R9 mask low blocks; R10 both enables, either channel alone
    step(2'b00, 1'b1, 1'b0, 8'h88, 1'b1, 1'b1);
    step(2'b01, 1'b0, 1'b1, 8'h00, 1'b0, 1'b1);
    #1 chk("R9 masked edge no irq", {7'b0, irq_pulse}, 8'h00);
    idle(2'b00);
    step(2'b10, 1'b0, 1'b1, 8'h00, 1'b1, 1'b1);
    #1 chk("R10 ch1 alone raises irq", {7'b0, irq_pulse}, 8'h01);
    idle(2'b00);
    step(2'b01, 1'b0, 1'b1, 8'h00, 1'b1, 1'b1);
    #1 chk("R10 ch0 alone raises irq", {7'b0, irq_pulse}, 8'h01);
    idle(2'b00);
    #1 chk("R9 single cycle pulse", {7'b0, irq_pulse}, 8'h00);

    // R8 pin gate off
    step(2'b11, 1'b0, 1'b1, 8'h00, 1'b1, 1'b0);
    chk("R8 pins low when disabled", {6'b0, pin_out}, 8'h00);

    // random mix
    for (int n = 0; n < 3000; n++) begin
      rl = 2'($urandom);
      rw = 8'($urandom);
      if (($urandom % 16) == 0)
        step(rl, 1'b1, 1'b0, rw, 1'($urandom), 1'($urandom));
      else if (($urandom % 8) == 0)
        step(rl, 1'b1, 1'b1, rw, 1'($urandom), 1'($urandom));
      else
        step(rl, 1'b0, 1'($urandom), rw, 1'($urandom % 4 != 0), 1'($urandom % 4 != 0));
    end

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule